// File: doc/BRIEF.md
# Command-Driven Glitch-Free Clock Switch

This block selects which of several free-running, mutually asynchronous clock sources drives the system clock. It also turns those sources on and off. Software controls it through a byte-wide write port. Each command is accepted only when it directly follows an unlock write, and only one command runs at a time. A switch moves the system clock from one source to another without runt pulses. The old branch is stopped on its low phase, and the new branch starts only after that stop has been seen in the new branch's own domain.

The control logic runs on `clk_i`. Source 0 is the recovery source, and it is the one selected out of reset. A drop in the ready indication of the selected source raises a failure flag. A recover command then forces the system clock back to source 0, even if the failed clock has stopped toggling. The clock-out pin carries the system clock when it is enabled, and it stays low while reset is held.

Top module: `clk_switch_ctrl`

## Requirements
- R1: In reset and just after release, `src_en_o` is 2'b01, `sel_o` is 0, and `busy_o`, `err_o`, `fail_o`, `wdt_en_o` and `avail_o` are all zero. Once reset is released, `sys_clk_o` follows source 0.
- R2: A command write has bit 7 clear, the command code in bits [3:0] and the source index in bit 4. It runs only if an unlock write of exactly 8'h80 came before it, inside the window. A command written without an unlock has no effect. Any other write cancels the unlock.
- R3: A command written on the 4th cycle after the unlock write is executed. A command written on the 5th cycle is ignored.
- R4: Code 2 sets the enable bit of the chosen source and code 1 clears it. `busy_o` is high while a command runs, and enable bits change only while it is high.
- R5: A command written while `busy_o` is high is dropped. It is not launched once the running command finishes.
- R6: Code 3 copies the synchronized ready input of the chosen source into its `avail_o` bit. The other `avail_o` bits are left unchanged.
- R7: Code 4 to an enabled, ready source updates `sel_o`. `busy_o` stays high until the new branch is running, after which `sys_clk_o` equals the new source clock. At no time are two branches running at once.
- R8: A switch to a source that is disabled or not ready sets `err_o` and leaves `sel_o` and the running clock unchanged. The next launched command that succeeds clears `err_o`.
- R9: Code 1 aimed at the selected source is rejected with `err_o` set, and the enable bits are left unchanged.
- R10: `fail_o` rises when the synchronized ready input of the selected source falls. Code 5 sets the enable bit of source 0, selects source 0 (even if the old source clock has stopped), makes `sys_clk_o` follow source 0, and clears `fail_o`.
- R11: Code 6 raises `wdt_en_o`, which then stays high until reset.
- R12: Codes 0 and 7 to 15 are not launched. `busy_o` stays low, and the enables, selection and flags keep their values.
- R13: `clko_o` is low while `rst_ni` is low. Outside reset, `clko_o` equals `sys_clk_o` when `clko_en_i` is 1 and is low when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Control clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe for the command port |
| wdata_i | input | 8 | Unlock value or command word |
| src_clk_i | input | 2 | Source clocks, bit 0 is the recovery source |
| src_rdy_i | input | 2 | Asynchronous ready indication for each source |
| clko_en_i | input | 1 | Enables the clock-out pin |
| sys_clk_o | output | 1 | Glitch-free system clock |
| clko_o | output | 1 | Clock-out pin |
| src_en_o | output | 2 | Enable for each source |
| avail_o | output | 2 | Ready snapshot for each source, taken by code 3 |
| sel_o | output | 1 | Selected source index |
| err_o | output | 1 | Last launched command was rejected |
| fail_o | output | 1 | Ready of the selected source dropped |
| busy_o | output | 1 | A command is running |
| wdt_en_o | output | 1 | Watchdog auto-reload enable request |

## Verification
The bench builds the block with its defaults: two sources, a four-cycle unlock window and two-stage synchronizers. The sources run at 14 ns and 22 ns against a 5 ns control clock, so each switch goes through an off-handshake and an on-handshake with different latencies in the two domains. This gives a busy period long enough to land an unlock and a command inside it. Stopping source 1 while it is selected drives the forced-off path of the recover command. With two sources, every enable/selection combination and the window edges on both sides can be reached.

// File: rtl/clk_sw_pkg.sv
`timescale 1ns/1ps
package clk_sw_pkg;
  typedef enum logic [3:0] {
    CMD_NONE    = 4'd0,
    CMD_OFF     = 4'd1,
    CMD_ON      = 4'd2,
    CMD_AVAIL   = 4'd3,
    CMD_SWITCH  = 4'd4,
    CMD_RECOVER = 4'd5,
    CMD_WDT     = 4'd6
  } cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_EXEC,
    ST_SWITCH
  } state_e;
endpackage

// File: rtl/clk_sw_sync.sv
`timescale 1ns/1ps
module clk_sw_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/clk_sw_branch.sv
`timescale 1ns/1ps
// One gated branch: the run flag is resynchronized on the falling edge of its own clock.
module clk_sw_branch #(
  parameter int STAGES = 2
) (
  input  logic src_clk_i,
  input  logic rst_ni,
  input  logic kill_i,
  input  logic want_i,
  output logic on_o,
  output logic gclk_o
);
  logic             arst_n;
  logic [STAGES-1:0] run_q;

  assign arst_n = rst_ni & ~kill_i;

  always_ff @(negedge src_clk_i or negedge arst_n) begin
    if (!arst_n) run_q <= '0;
    else         run_q <= {run_q[STAGES-2:0], want_i};
  end

  assign on_o   = run_q[STAGES-1];
  assign gclk_o = src_clk_i & on_o;
endmodule

// File: rtl/clk_sw_guard.sv
`timescale 1ns/1ps
// Unlock window: an exact unlock write arms for WIN cycles; any other write disarms.
module clk_sw_guard #(
  parameter int DW  = 8,
  parameter int WIN = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          cmd_vld_o
);
  localparam int CW = $clog2(WIN + 1);
  localparam logic [CW-1:0] WIN_L = CW'(WIN);
  localparam logic [DW-1:0] UNLOCK = DW'(1) << (DW - 1);

  logic [CW-1:0] win_q;
  logic          unlock;

  assign unlock    = wr_i && (wdata_i == UNLOCK);
  assign cmd_vld_o = wr_i && !wdata_i[DW-1] && (win_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            win_q <= '0;
    else if (unlock)        win_q <= WIN_L;
    else if (wr_i)          win_q <= '0;
    else if (win_q != '0)   win_q <= win_q - 1'b1;
  end
endmodule

// File: rtl/clk_switch_ctrl.sv
`timescale 1ns/1ps
module clk_switch_ctrl
  import clk_sw_pkg::*;
#(
  parameter int N_SRC   = 2,
  parameter int WIN     = 4,
  parameter int SYNC    = 2,
  parameter int REC_SRC = 0,
  parameter int DW      = 8,
  localparam int SEL_W  = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [N_SRC-1:0] src_clk_i,
  input  logic [N_SRC-1:0] src_rdy_i,
  input  logic             clko_en_i,
  output logic             sys_clk_o,
  output logic             clko_o,
  output logic [N_SRC-1:0] src_en_o,
  output logic [N_SRC-1:0] avail_o,
  output logic [SEL_W-1:0] sel_o,
  output logic             err_o,
  output logic             fail_o,
  output logic             busy_o,
  output logic             wdt_en_o
);
  localparam logic [N_SRC-1:0] REC_HOT = N_SRC'(1) << REC_SRC;
  localparam logic [SEL_W-1:0] REC_IDX = SEL_W'(REC_SRC);

  function automatic logic [N_SRC-1:0] hot(input logic [SEL_W-1:0] s);
    logic [N_SRC-1:0] r;
    r    = '0;
    r[s] = 1'b1;
    return r;
  endfunction

  logic             cmd_vld, known;
  cmd_e             code;
  logic [SEL_W-1:0] cmd_src;
  logic [N_SRC-1:0] rdy_s, rdy_d, on, on_s, want, gclk;

  state_e           state_q;
  cmd_e             op_q;
  logic [SEL_W-1:0] op_src_q;
  logic [N_SRC-1:0] en_q, sel_req_q, kill_q, avail_q;
  logic [SEL_W-1:0] sel_q;
  logic             err_q, fail_q, wdt_q, src_ok;

  clk_sw_guard #(.DW(DW), .WIN(WIN)) u_guard (
    .clk_i, .rst_ni, .wr_i, .wdata_i, .cmd_vld_o(cmd_vld)
  );

  assign code    = cmd_e'(wdata_i[3:0]);
  assign cmd_src = wdata_i[4 +: SEL_W];
  assign known   = (wdata_i[3:0] >= 4'd1) && (wdata_i[3:0] <= 4'd6);

  clk_sw_sync #(.W(N_SRC), .STAGES(SYNC)) u_rdy_sync (
    .clk_i, .rst_ni, .d_i(src_rdy_i), .q_o(rdy_s)
  );
  clk_sw_sync #(.W(N_SRC), .STAGES(SYNC)) u_on_sync (
    .clk_i, .rst_ni, .d_i(on), .q_o(on_s)
  );

  // A branch may start only once every other branch reports stopped.
  always_comb begin
    for (int i = 0; i < N_SRC; i++)
      want[i] = sel_req_q[i] & ~|(on & ~(N_SRC'(1) << i));
  end

  for (genvar g = 0; g < N_SRC; g++) begin : g_branch
    clk_sw_branch #(.STAGES(SYNC)) u_br (
      .src_clk_i(src_clk_i[g]), .rst_ni, .kill_i(kill_q[g]),
      .want_i(want[g]), .on_o(on[g]), .gclk_o(gclk[g])
    );
  end

  assign src_ok = (32'(op_src_q) < N_SRC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      op_q      <= CMD_NONE;
      op_src_q  <= '0;
      en_q      <= REC_HOT;
      sel_req_q <= REC_HOT;
      sel_q     <= REC_IDX;
      kill_q    <= '0;
      avail_q   <= '0;
      err_q     <= 1'b0;
      fail_q    <= 1'b0;
      wdt_q     <= 1'b0;
      rdy_d     <= '0;
    end else begin
      rdy_d <= rdy_s;
      if (rdy_d[sel_q] && !rdy_s[sel_q]) fail_q <= 1'b1;
      unique case (state_q)
        ST_IDLE: begin
          if (cmd_vld && known) begin
            op_q     <= code;
            op_src_q <= cmd_src;
            state_q  <= ST_EXEC;
          end
        end
        ST_EXEC: begin
          err_q   <= 1'b0;
          state_q <= ST_IDLE;
          unique case (op_q)
            CMD_OFF:
              if (!src_ok || op_src_q == sel_q) err_q <= 1'b1;
              else en_q[op_src_q] <= 1'b0;
            CMD_ON:
              if (!src_ok) err_q <= 1'b1;
              else en_q[op_src_q] <= 1'b1;
            CMD_AVAIL:
              if (!src_ok) err_q <= 1'b1;
              else avail_q[op_src_q] <= rdy_s[op_src_q];
            CMD_SWITCH:
              if (!src_ok || !en_q[op_src_q] || !rdy_s[op_src_q]) err_q <= 1'b1;
              else begin
                sel_q     <= op_src_q;
                sel_req_q <= hot(op_src_q);
                state_q   <= ST_SWITCH;
              end
            CMD_RECOVER: begin
              en_q[REC_SRC] <= 1'b1;
              sel_q         <= REC_IDX;
              sel_req_q     <= REC_HOT;
              kill_q        <= ~REC_HOT;
              fail_q        <= 1'b0;
              state_q       <= ST_SWITCH;
            end
            CMD_WDT: wdt_q <= 1'b1;
            default: ;
          endcase
        end
        ST_SWITCH: begin
          if (on_s == sel_req_q) begin
            kill_q  <= '0;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign sys_clk_o = |gclk;
  assign clko_o    = sys_clk_o & clko_en_i & rst_ni;
  assign src_en_o  = en_q;
  assign avail_o   = avail_q;
  assign sel_o     = sel_q;
  assign err_o     = err_q;
  assign fail_o    = fail_q;
  assign busy_o    = (state_q != ST_IDLE);
  assign wdt_en_o  = wdt_q;
endmodule

// File: rtl/clk_switch_ctrl_chk.sv
`timescale 1ns/1ps
module clk_switch_ctrl_chk #(
  parameter int N_SRC = 2,
  parameter int SEL_W = 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             busy_o,
  input logic [SEL_W-1:0] sel_o,
  input logic             err_o,
  input logic             fail_o,
  input logic             wdt_en_o,
  input logic             clko_o,
  input logic [N_SRC-1:0] src_en_o,
  input logic [N_SRC-1:0] on_s
);
  p_en_busy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(src_en_o) |-> $past(busy_o));

  p_one_branch_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(on_s));

  p_sel_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sel_o) |-> $past(busy_o));

  p_err_keeps_sel_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> $stable(sel_o));

  p_fail_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fail_o) |-> $past(busy_o));

  p_wdt_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_en_o |=> wdt_en_o);

  p_clko_quiet_r13: assert property (@(posedge clk_i)
    !rst_ni |-> !clko_o);
endmodule

bind clk_switch_ctrl clk_switch_ctrl_chk #(.N_SRC(N_SRC), .SEL_W(SEL_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .sel_o(sel_o),
  .err_o(err_o), .fail_o(fail_o), .wdt_en_o(wdt_en_o), .clko_o(clko_o),
  .src_en_o(src_en_o), .on_s(on_s)
);

// File: tb/clk_switch_ctrl_test.sv
`timescale 1ns/1ps
module clk_switch_ctrl_test;
  logic       clk_i = 1'b0, rst_ni = 1'b0, wr_i = 1'b0, clko_en_i = 1'b1;
  logic [7:0] wdata_i = '0;
  logic       src0 = 1'b0, src1 = 1'b0, src1_run = 1'b1;
  logic [1:0] src_rdy_i = 2'b11;
  logic       sys_clk_o, clko_o, err_o, fail_o, busy_o, wdt_en_o;
  logic [1:0] src_en_o, avail_o;
  logic [0:0] sel_o;
  int n_run = 0, n_fail = 0;

  always #2.5 clk_i = ~clk_i;
  always #7   src0  = ~src0;
  always #11  if (src1_run) src1 = ~src1;

  clk_switch_ctrl uut (
    .clk_i, .rst_ni, .wr_i, .wdata_i, .src_clk_i({src1, src0}), .src_rdy_i,
    .clko_en_i, .sys_clk_o, .clko_o, .src_en_o, .avail_o, .sel_o,
    .err_o, .fail_o, .busy_o, .wdt_en_o
  );

  // {command byte, expected enables, expected err, expected sel}
  localparam logic [11:0] VEC [0:9] = '{
    {8'h12, 2'b11, 1'b0, 1'b0},  // enable 1
    {8'h11, 2'b01, 1'b0, 1'b0},  // disable 1
    {8'h01, 2'b01, 1'b1, 1'b0},  // R9 disable selected
    {8'h17, 2'b01, 1'b1, 1'b0},  // R12 unknown code, err kept
    {8'h14, 2'b01, 1'b1, 1'b0},  // R8 switch to disabled source
    {8'h12, 2'b11, 1'b0, 1'b0},
    {8'h14, 2'b11, 1'b0, 1'b1},  // R7 switch to 1
    {8'h11, 2'b11, 1'b1, 1'b1},  // R9
    {8'h04, 2'b11, 1'b0, 1'b0},
    {8'h11, 2'b01, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // called at a negedge; the write lands on the next posedge
  task automatic wr(input logic [7:0] d);
    wr_i = 1'b1; wdata_i = d;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] d);
    wr(8'h80);
    wr(d);
  endtask

  task automatic wait_idle();
    repeat (2) @(negedge clk_i);
    for (int i = 0; i < 400; i++) begin
      if (!busy_o) break;
      @(negedge clk_i);
    end
  endtask

  // sys_clk_o (and clko_o when on) must track the chosen source clock
  task automatic follow(input string req, input int k, input logic co);
    int bad = 0;
    for (int i = 0; i < 6; i++) begin
      if (k == 0) @(posedge src0); else @(posedge src1);
      #1 if (sys_clk_o !== 1'b1 || clko_o !== co) bad++;
      if (k == 0) @(negedge src0); else @(negedge src1);
      #1 if (sys_clk_o !== 1'b0 || clko_o !== 1'b0) bad++;
    end
    check(req, bad, 0);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int cl = 0;
    for (int i = 0; i < 40; i++) begin
      #1.7 if (clko_o !== 1'b0) cl++;
    end
    check("R13 clko in reset", cl, 0);
    check("R1 reset state", {src_en_o, avail_o, sel_o, err_o, fail_o, busy_o, wdt_en_o},
          {2'b01, 2'b00, 1'b0, 4'b0});
    @(negedge clk_i); rst_ni = 1'b1;
    repeat (12) @(negedge clk_i);
    follow("R1 source 0 after reset", 0, 1'b1);
    @(negedge clk_i);

    for (int v = 0; v < 10; v++) begin
      cmd(VEC[v][11:4]);
      wait_idle();
      check($sformatf("R4/R9 vec%0d enables", v), src_en_o, VEC[v][3:2]);
      check($sformatf("R8/R9 vec%0d err", v), err_o, VEC[v][1]);
      check($sformatf("R7 vec%0d sel", v), sel_o, VEC[v][0]);
    end

    wr(8'h12); wait_idle();
    check("R2 no unlock", src_en_o, 2'b01);
    wr(8'h80); repeat (4) @(negedge clk_i); wr(8'h12); wait_idle();
    check("R3 window lapsed", src_en_o, 2'b01);
    wr(8'h80); repeat (3) @(negedge clk_i); wr(8'h12); wait_idle();
    check("R3 last window cycle", src_en_o, 2'b11);

    cmd(8'h13); wait_idle();
    check("R6 avail set", avail_o, 2'b10);
    src_rdy_i[1] = 1'b0; repeat (4) @(negedge clk_i);
    cmd(8'h13); wait_idle();
    check("R6 avail clear", avail_o, 2'b00);
    cmd(8'h14); wait_idle();
    check("R8 unready target", {err_o, sel_o}, 2'b10);
    src_rdy_i[1] = 1'b1; repeat (4) @(negedge clk_i);

    cmd(8'h14);
    check("R5 busy during switch", busy_o, 1'b1);
    cmd(8'h01);
    wait_idle(); repeat (4) @(negedge clk_i);
    check("R5 dropped command", {src_en_o, sel_o}, 3'b111);
    follow("R7 follows source 1", 1, 1'b1);

    @(negedge clk_i); src1_run = 1'b0; src_rdy_i[1] = 1'b0;
    repeat (6) @(negedge clk_i);
    check("R10 fail flag", fail_o, 1'b1);
    cmd(8'h05); wait_idle();
    check("R10 recover state", {sel_o, fail_o, src_en_o[0]}, 3'b001);
    follow("R10 follows source 0", 0, 1'b1);
    @(negedge clk_i); src1_run = 1'b1; src_rdy_i[1] = 1'b1;
    repeat (4) @(negedge clk_i);

    cmd(8'h0F);
    check("R12 not launched", busy_o, 1'b0);
    wait_idle();
    check("R12 state kept", {src_en_o, sel_o, err_o, wdt_en_o}, {2'b11, 3'b000});

    cmd(8'h06); wait_idle();
    check("R11 watchdog request", wdt_en_o, 1'b1);
    cmd(8'h12); wait_idle();
    check("R11 watchdog sticky", wdt_en_o, 1'b1);

    clko_en_i = 1'b0;
    follow("R13 clko gated off", 0, 1'b0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule